// File: doc/BRIEF.md
# Disk Command Channel Controller

This block is the command-side front end of a moving-head disk controller that serves four drives. The host writes a 16-bit command word into a holding register and then pulses a start strobe. The block decodes the function and the drive from the held word. It then does one of two things. For seek, status, check and address-record it starts a parameter exchange on the data channel. For read, write, refine and initialize it starts a drive operation and marks the controller busy. It holds the control, command and flag flip-flops of the command channel, the busy indicator, the transfer-in-progress bit, the attention-polling enable and one attention bit per drive.

A sequencer outside the block does the actual work. It receives a one-cycle start pulse that carries the function, the drive and the kind of start. It reports back through four events:
- the exchange finished,
- the drive operation finished,
- the data transfer ended,
- a drive completed its seek.

When the host reads the command channel, it gets a live bitmap of the drives with attention pending, either loaded alone or merged into its word. A clear-control strobe aborts whatever is running.

The controller is a three-state machine:
- **CS_IDLE**: no exchange or drive operation is pending.
- **CS_EXCH**: a parameter exchange is outstanding.
- **CS_RUN**: a drive operation holds the controller busy.

Its transitions are:
- **accept-exchange**: IDLE, or any state whose command flip-flop is clear, goes to EXCH.
- **accept-operation**: goes to RUN.
- **exchange-done**: EXCH goes to IDLE for seek, status and address record.
- **check-promote**: EXCH goes to RUN for check data.
- **operation-done**: RUN goes to IDLE.
- **abort**: any state goes to IDLE on clear-control.

Top module: `dcc_cmd_chan`

## Requirements
- R1: The function is command word bits 15:12 and the drive is bits 1:0. On an accepted start, the block gives a one-cycle start pulse on the next cycle.
  - It carries the function and the drive.
  - start_xch=1 for the exchange codes 0 (status), 3 (seek), 6 (check) and 11 (address record).
  - start_xch=0 for the operation codes 1 (write), 2 (read), 5 (refine) and 9 (initialize).
  - Any other code sets control and command but gives no pulse and no busy.
- R2: A start strobe while the command flip-flop is set is ignored: no pulse, busy unchanged.
- R3: An accepted start (command flip-flop clear) sets both the control and the command flip-flops.
- R4: Starting a drive operation sets busy to drive+1 and sets transfer-in-progress. It also clears that drive's attention bit.
- R5: Operation-done while busy does four things:
  - it sets attention for drive busy-1;
  - it sets the flag and the flag buffer;
  - it clears command;
  - it returns busy and transfer-in-progress to 0.
- R6: Accepting a seek sets the polling enable.
  - A seek completion always sets that drive's attention bit.
  - It also sets the flag and clears command only while polling is enabled.
- R7: Clear-control clears control, command, busy, transfer-in-progress and the polling enable. It returns the machine to idle and gives a one-cycle abort pulse.
- R8: The read port returns the attention bitmap in bits 3:0 (bit n for drive n).
  - With rd_load=1 all other bits are 0.
  - With rd_load=0 the bitmap is ORed into rd_in.
- R9: A status start clears the data-channel flag. When its exchange is done:
  - the data-channel flag is set;
  - that drive's attention bit is cleared;
  - command is cleared;
  - polling is enabled;
  - the flag is set if and only if another drive still has attention.
- R10: Reset leaves busy, transfer, poll, control, command, attention and the start and abort pulses at 0. It leaves the flag, the flag buffer and the data-channel flag at 1.
- R11: When a check exchange is done, the block becomes busy with drive+1 and sets transfer-in-progress. It also gives a second start pulse with function 6 and start_xch=0.
- R12: When an address-record exchange is done, the block sets that drive's attention bit, sets the flag and clears command.
- R13: Transfer-end clears transfer-in-progress and leaves busy unchanged.
- R14: The host set-flag strobe sets the flag and the flag buffer. The clear-flag strobe clears both, unless an internal flag-set event happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Load the command holding register |
| cmd_wdata | input | 16 | Command word from the host |
| stc | input | 1 | Start strobe |
| clc | input | 1 | Clear-control (abort) strobe |
| stf | input | 1 | Host set-flag strobe |
| clf | input | 1 | Host clear-flag strobe |
| rd_load | input | 1 | 1 = load read, 0 = merge read |
| rd_in | input | 16 | Host word to merge into |
| rd_out | output | 16 | Read result with attention bitmap |
| xch_done | input | 1 | Parameter exchange finished |
| op_done | input | 1 | Drive operation finished |
| xfer_end | input | 1 | Data transfer ended |
| seek_done | input | 1 | A drive finished seeking |
| seek_drv | input | 2 | Drive that finished seeking |
| start_vld | output | 1 | One-cycle start pulse to the sequencer |
| start_xch | output | 1 | 1 = exchange start, 0 = drive operation |
| start_fn | output | 4 | Function of the start |
| start_drv | output | 2 | Drive of the start |
| abort | output | 1 | One-cycle abort pulse |
| busy | output | 3 | 0 = free, else drive+1 |
| xfer | output | 1 | Transfer in progress |
| poll | output | 1 | Attention-polling enable |
| ctl | output | 1 | Control flip-flop |
| cmd | output | 1 | Command flip-flop |
| flag | output | 1 | Command-channel flag |
| flag_buf | output | 1 | Command-channel flag buffer |
| dch_flag | output | 1 | Data-channel flag |
| attn | output | 4 | Attention bit per drive |

## Verification
On every cycle the properties check the following:
- an accepted start raises control and command;
- a start strobe with command set leaves busy alone;
- clear-control leaves the whole run state clear;
- busy never exceeds the drive count;
- operation-done frees the controller and raises the flag;
- every exchange start pulse carries an exchange code;
- a merge read keeps all of the host's bits.

The following can only be shown by the scenarios, run against a behavioural reference model:
- the polling gate on seek completion;
- the status read's conditional flag, which depends on the other drives' attention bits;
- the check-to-run promotion with its second start pulse;
- the address-record attention.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_STATUS = 4'd0,
        FN_WRITE  = 4'd1,
        FN_READ   = 4'd2,
        FN_SEEK   = 4'd3,
        FN_REFINE = 4'd5,
        FN_CHECK  = 4'd6,
        FN_INIT   = 4'd9,
        FN_ADDR   = 4'd11
    } dcc_fn_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_EXCH = 2'd1,
        CS_RUN  = 2'd2
    } dcc_state_e;

endpackage

// File: rtl/dcc_decode.sv
module dcc_decode
    import dcc_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output logic            is_xch,
    output logic            is_op,
    output logic            is_seek,
    output logic            is_status
);
    always_comb begin
        is_xch    = 1'b0;
        is_op     = 1'b0;
        is_seek   = 1'b0;
        is_status = 1'b0;
        case (fn)
            FN_STATUS: begin
                is_xch    = 1'b1;
                is_status = 1'b1;
            end
            FN_SEEK: begin
                is_xch  = 1'b1;
                is_seek = 1'b1;
            end
            FN_CHECK, FN_ADDR:                   is_xch = 1'b1;
            FN_WRITE, FN_READ, FN_REFINE, FN_INIT: is_op  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dcc_attn.sv
module dcc_attn #(
    parameter int NUM_DRV = 4,
    parameter int WORD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DRV-1:0] set_mask,
    input  logic [NUM_DRV-1:0] clr_mask,
    input  logic               rd_load,
    input  logic [WORD_W-1:0]  rd_in,
    output logic [WORD_W-1:0]  rd_out,
    output logic [NUM_DRV-1:0] attn
);
    localparam int PAD_W = WORD_W - NUM_DRV;

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           attn[d] <= 1'b0;
            else if (clr_mask[d]) attn[d] <= 1'b0;
            else if (set_mask[d]) attn[d] <= 1'b1;
        end
    end

    always_comb begin
        rd_out = (rd_load ? '0 : rd_in) | {{PAD_W{1'b0}}, attn};
    end
endmodule

// File: rtl/dcc_flags.sv
module dcc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_set,
    input  logic ctl_clr,
    input  logic cmd_set,
    input  logic cmd_clr,
    input  logic flg_set,
    input  logic flg_clr,
    input  logic dch_set,
    input  logic dch_clr,
    output logic ctl,
    output logic cmd,
    output logic flag,
    output logic flag_buf,
    output logic dch_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl      <= 1'b0;
            cmd      <= 1'b0;
            flag     <= 1'b1;
            flag_buf <= 1'b1;
            dch_flag <= 1'b1;
        end else begin
            if (ctl_set)      ctl <= 1'b1;
            else if (ctl_clr) ctl <= 1'b0;

            if (cmd_set)      cmd <= 1'b1;
            else if (cmd_clr) cmd <= 1'b0;

            if (flg_set) begin
                flag     <= 1'b1;
                flag_buf <= 1'b1;
            end else if (flg_clr) begin
                flag     <= 1'b0;
                flag_buf <= 1'b0;
            end

            if (dch_clr)      dch_flag <= 1'b0;
            else if (dch_set) dch_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/dcc_cmd_chan.sv
module dcc_cmd_chan
    import dcc_pkg::*;
#(
    parameter int NUM_DRV = 4,
    parameter int WORD_W  = 16,
    parameter int FN_LSB  = 12,
    localparam int DRV_W  = $clog2(NUM_DRV),
    localparam int BUSY_W = $clog2(NUM_DRV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [WORD_W-1:0]  cmd_wdata,
    input  logic               stc,
    input  logic               clc,
    input  logic               stf,
    input  logic               clf,
    input  logic               rd_load,
    input  logic [WORD_W-1:0]  rd_in,
    output logic [WORD_W-1:0]  rd_out,
    input  logic               xch_done,
    input  logic               op_done,
    input  logic               xfer_end,
    input  logic               seek_done,
    input  logic [DRV_W-1:0]   seek_drv,
    output logic               start_vld,
    output logic               start_xch,
    output logic [FN_W-1:0]    start_fn,
    output logic [DRV_W-1:0]   start_drv,
    output logic               abort,
    output logic [BUSY_W-1:0]  busy,
    output logic               xfer,
    output logic               poll,
    output logic               ctl,
    output logic               cmd,
    output logic               flag,
    output logic               flag_buf,
    output logic               dch_flag,
    output logic [NUM_DRV-1:0] attn
);
    // Held command word and its fields
    logic [WORD_W-1:0] word_q;
    dcc_fn_e           word_fn;
    logic [DRV_W-1:0]  word_drv;
    logic is_xch, is_op, is_seek, is_status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (cmd_wr) word_q <= cmd_wdata;
    end

    assign word_fn  = dcc_fn_e'(word_q[FN_LSB +: FN_W]);
    assign word_drv = word_q[DRV_W-1:0];

    dcc_decode u_dec (
        .fn       (word_fn),
        .is_xch   (is_xch),
        .is_op    (is_op),
        .is_seek  (is_seek),
        .is_status(is_status)
    );

    // Machine state and registered outputs
    dcc_state_e        state_q, nx_state;
    dcc_fn_e           fn_q, nx_fn;
    logic [DRV_W-1:0]  drv_q, nx_drv;
    logic [BUSY_W-1:0] busy_q, nx_busy;
    logic              xfer_q, nx_xfer;
    logic              poll_q, nx_poll;
    logic              sv_q, nx_sv, sx_q, nx_sx, ab_q, nx_ab;
    logic [FN_W-1:0]   sf_q, nx_sf;
    logic [DRV_W-1:0]  sd_q, nx_sd;

    logic [NUM_DRV-1:0] set_mask, clr_mask, drv_bit;
    logic ctl_set, ctl_clr, cmd_set, cmd_clr, flg_set, dch_set, dch_clr;
    logic accept;
    logic [DRV_W-1:0] done_drv;

    assign accept   = stc && !cmd && !clc;
    assign done_drv = DRV_W'(busy_q - BUSY_W'(1));
    assign drv_bit  = NUM_DRV'(1) << drv_q;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            fn_q    <= FN_STATUS;
            drv_q   <= '0;
        end else begin
            state_q <= nx_state;
            fn_q    <= nx_fn;
            drv_q   <= nx_drv;
        end
    end

    // Output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
            xfer_q <= 1'b0;
            poll_q <= 1'b0;
            sv_q   <= 1'b0;
            sx_q   <= 1'b0;
            sf_q   <= '0;
            sd_q   <= '0;
            ab_q   <= 1'b0;
        end else begin
            busy_q <= nx_busy;
            xfer_q <= nx_xfer;
            poll_q <= nx_poll;
            sv_q   <= nx_sv;
            sx_q   <= nx_sx;
            sf_q   <= nx_sf;
            sd_q   <= nx_sd;
            ab_q   <= nx_ab;
        end
    end

    // Next-state and event decoding; later items in the list take precedence
    always_comb begin
        nx_state = state_q;
        nx_fn    = fn_q;
        nx_drv   = drv_q;
        nx_busy  = busy_q;
        nx_xfer  = xfer_q;
        nx_poll  = poll_q;
        nx_sv    = 1'b0;
        nx_sx    = sx_q;
        nx_sf    = sf_q;
        nx_sd    = sd_q;
        nx_ab    = 1'b0;
        set_mask = '0;
        clr_mask = '0;
        ctl_set  = 1'b0;
        ctl_clr  = 1'b0;
        cmd_set  = 1'b0;
        cmd_clr  = 1'b0;
        flg_set  = 1'b0;
        dch_set  = 1'b0;
        dch_clr  = 1'b0;

        if (clc) begin
            // abort: any state to idle
            ctl_clr  = 1'b1;
            cmd_clr  = 1'b1;
            nx_state = CS_IDLE;
            nx_busy  = '0;
            nx_xfer  = 1'b0;
            nx_poll  = 1'b0;
            nx_ab    = 1'b1;
        end else begin
            if (xfer_end) nx_xfer = 1'b0;

            if (seek_done) begin
                set_mask[seek_drv] = 1'b1;
                if (poll_q) begin
                    flg_set = 1'b1;
                    cmd_clr = 1'b1;
                end
            end

            unique case (state_q)
                CS_EXCH: begin
                    if (xch_done) begin
                        // exchange-done
                        dch_set  = 1'b1;
                        nx_state = CS_IDLE;
                        case (fn_q)
                            FN_STATUS: begin
                                clr_mask[drv_q] = 1'b1;
                                cmd_clr = 1'b1;
                                nx_poll = 1'b1;
                                if (|(attn & ~drv_bit)) flg_set = 1'b1;
                            end
                            FN_CHECK: begin
                                // check-promote
                                nx_state        = CS_RUN;
                                nx_busy         = BUSY_W'(drv_q) + BUSY_W'(1);
                                nx_xfer         = 1'b1;
                                clr_mask[drv_q] = 1'b1;
                                nx_sv           = 1'b1;
                                nx_sx           = 1'b0;
                                nx_sf           = FN_CHECK;
                                nx_sd           = drv_q;
                            end
                            FN_ADDR: begin
                                set_mask[drv_q] = 1'b1;
                                flg_set = 1'b1;
                                cmd_clr = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                CS_RUN: begin
                    if (op_done) begin
                        // operation-done
                        set_mask[done_drv] = 1'b1;
                        flg_set  = 1'b1;
                        cmd_clr  = 1'b1;
                        nx_busy  = '0;
                        nx_xfer  = 1'b0;
                        nx_state = CS_IDLE;
                    end
                end
                default: ;
            endcase

            if (accept) begin
                ctl_set = 1'b1;
                cmd_set = 1'b1;
                if (is_xch) begin
                    // accept-exchange
                    nx_state = CS_EXCH;
                    nx_fn    = word_fn;
                    nx_drv   = word_drv;
                    nx_sv    = 1'b1;
                    nx_sx    = 1'b1;
                    nx_sf    = word_fn;
                    nx_sd    = word_drv;
                    if (is_seek)   nx_poll = 1'b1;
                    if (is_status) dch_clr = 1'b1;
                end else if (is_op) begin
                    // accept-operation
                    nx_state           = CS_RUN;
                    nx_fn              = word_fn;
                    nx_drv             = word_drv;
                    nx_busy            = BUSY_W'(word_drv) + BUSY_W'(1);
                    nx_xfer            = 1'b1;
                    clr_mask[word_drv] = 1'b1;
                    nx_sv              = 1'b1;
                    nx_sx              = 1'b0;
                    nx_sf              = word_fn;
                    nx_sd              = word_drv;
                end
            end
        end
    end

    dcc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_set (ctl_set),
        .ctl_clr (ctl_clr),
        .cmd_set (cmd_set),
        .cmd_clr (cmd_clr),
        .flg_set (flg_set || stf),
        .flg_clr (clf),
        .dch_set (dch_set),
        .dch_clr (dch_clr),
        .ctl     (ctl),
        .cmd     (cmd),
        .flag    (flag),
        .flag_buf(flag_buf),
        .dch_flag(dch_flag)
    );

    dcc_attn #(.NUM_DRV(NUM_DRV), .WORD_W(WORD_W)) u_attn (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .rd_load (rd_load),
        .rd_in   (rd_in),
        .rd_out  (rd_out),
        .attn    (attn)
    );

    assign start_vld = sv_q;
    assign start_xch = sx_q;
    assign start_fn  = sf_q;
    assign start_drv = sd_q;
    assign abort     = ab_q;
    assign busy      = busy_q;
    assign xfer      = xfer_q;
    assign poll      = poll_q;
endmodule

// File: rtl/dcc_cmd_chan_chk.sv
module dcc_cmd_chan_chk #(
    parameter int NUM_DRV = 4,
    parameter int WORD_W  = 16,
    localparam int BUSY_W = $clog2(NUM_DRV + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stc,
    input logic               clc,
    input logic               rd_load,
    input logic [WORD_W-1:0]  rd_in,
    input logic [WORD_W-1:0]  rd_out,
    input logic               xch_done,
    input logic               op_done,
    input logic               seek_done,
    input logic               start_vld,
    input logic               start_xch,
    input logic [3:0]         start_fn,
    input logic               abort,
    input logic [BUSY_W-1:0]  busy,
    input logic               xfer,
    input logic               poll,
    input logic               ctl,
    input logic               cmd,
    input logic               flag
);
    AST_ACCEPT_SETS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (stc && !cmd && !clc) |=> (ctl && cmd));  // R3

    AST_STC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stc && cmd && !clc && !xch_done && !op_done && !seek_done) |=> $stable(busy));  // R2

    AST_CLC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clc |=> (!ctl && !cmd && busy == '0 && !xfer && !poll && abort));  // R7

    AST_BUSY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy <= BUSY_W'(NUM_DRV));  // R4

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && busy != '0 && !clc && !stc) |=> (busy == '0 && flag));  // R5

    AST_XCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vld && start_xch) |-> (start_fn == 4'd0 || start_fn == 4'd3 ||
                                      start_fn == 4'd6 || start_fn == 4'd11));  // R1

    AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |-> ((rd_out & rd_in) == rd_in));  // R8
endmodule

bind dcc_cmd_chan dcc_cmd_chan_chk #(.NUM_DRV(NUM_DRV), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stc      (stc),
    .clc      (clc),
    .rd_load  (rd_load),
    .rd_in    (rd_in),
    .rd_out   (rd_out),
    .xch_done (xch_done),
    .op_done  (op_done),
    .seek_done(seek_done),
    .start_vld(start_vld),
    .start_xch(start_xch),
    .start_fn (start_fn),
    .abort    (abort),
    .busy     (busy),
    .xfer     (xfer),
    .poll     (poll),
    .ctl      (ctl),
    .cmd      (cmd),
    .flag     (flag)
);

// File: tb/tb_dcc_cmd_chan.sv
`timescale 1ns/1ps
module tb_dcc_cmd_chan;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, stc = 0, clc = 0, stf = 0, clf = 0, rd_load = 0;
    logic [15:0] cmd_wdata = '0, rd_in = '0, rd_out;
    logic xch_done = 0, op_done = 0, xfer_end = 0, seek_done = 0;
    logic [1:0] seek_drv = '0;
    logic start_vld, start_xch, abort, xfer, poll, ctl, cmd, flag, flag_buf, dch_flag;
    logic [3:0] start_fn, attn;
    logic [1:0] start_drv;
    logic [2:0] busy;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dcc_cmd_chan dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .stc(stc), .clc(clc), .stf(stf), .clf(clf), .rd_load(rd_load),
        .rd_in(rd_in), .rd_out(rd_out), .xch_done(xch_done), .op_done(op_done),
        .xfer_end(xfer_end), .seek_done(seek_done), .seek_drv(seek_drv),
        .start_vld(start_vld), .start_xch(start_xch), .start_fn(start_fn),
        .start_drv(start_drv), .abort(abort), .busy(busy), .xfer(xfer),
        .poll(poll), .ctl(ctl), .cmd(cmd), .flag(flag), .flag_buf(flag_buf),
        .dch_flag(dch_flag), .attn(attn)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model: mode 0 idle, 1 exchange pending, 2 running
    int  m_mode, m_fn, m_drv, m_busy;
    bit  m_ctl, m_cmd, m_flg, m_fbf, m_dch, m_xfer, m_poll;
    bit  m_sv, m_sx, m_ab, m_valid;
    int  m_sf, m_sd;
    bit [3:0]  m_attn;
    bit [15:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_fn = 0; m_drv = 0; m_busy = 0;
            m_ctl = 0; m_cmd = 0; m_flg = 1; m_fbf = 1; m_dch = 1;
            m_xfer = 0; m_poll = 0; m_sv = 0; m_sx = 0; m_ab = 0;
            m_sf = 0; m_sd = 0; m_attn = 0; m_word = 0; m_valid = 1;
        end else begin
            bit fset;
            bit old_cmd;
            bit old_poll;
            bit [3:0] old_attn;
            int wf;
            int wd;
            fset = 0;
            old_cmd = m_cmd;
            old_poll = m_poll;
            old_attn = m_attn;
            wf = int'(m_word[15:12]);
            wd = int'(m_word[1:0]);
            m_sv = 0; m_ab = 0;
            if (clc) begin
                m_ctl = 0; m_cmd = 0; m_busy = 0; m_xfer = 0; m_poll = 0;
                m_mode = 0; m_ab = 1;
            end else begin
                if (xfer_end) m_xfer = 0;
                if (seek_done) begin
                    m_attn[seek_drv] = 1;
                    if (old_poll) begin fset = 1; m_cmd = 0; end
                end
                if (m_mode == 1 && xch_done) begin
                    m_dch = 1; m_mode = 0;
                    if (m_fn == 0) begin
                        m_attn[m_drv] = 0; m_cmd = 0; m_poll = 1;
                        if ((old_attn & ~(4'b1 << m_drv)) != 0) fset = 1;
                    end else if (m_fn == 6) begin
                        m_mode = 2; m_busy = m_drv + 1; m_xfer = 1; m_attn[m_drv] = 0;
                        m_sv = 1; m_sx = 0; m_sf = 6; m_sd = m_drv;
                    end else if (m_fn == 11) begin
                        m_attn[m_drv] = 1; fset = 1; m_cmd = 0;
                    end
                end else if (m_mode == 2 && op_done) begin
                    m_attn[m_busy - 1] = 1; fset = 1; m_cmd = 0;
                    m_busy = 0; m_xfer = 0; m_mode = 0;
                end
                if (stc && !old_cmd) begin
                    m_ctl = 1; m_cmd = 1;
                    if (wf == 0 || wf == 3 || wf == 6 || wf == 11) begin
                        m_mode = 1; m_fn = wf; m_drv = wd;
                        m_sv = 1; m_sx = 1; m_sf = wf; m_sd = wd;
                        if (wf == 3) m_poll = 1;
                        if (wf == 0) m_dch = 0;
                    end else if (wf == 1 || wf == 2 || wf == 5 || wf == 9) begin
                        m_mode = 2; m_fn = wf; m_drv = wd; m_busy = wd + 1; m_xfer = 1;
                        m_attn[wd] = 0;
                        m_sv = 1; m_sx = 0; m_sf = wf; m_sd = wd;
                    end
                end
            end
            if (fset || stf) begin m_flg = 1; m_fbf = 1; end
            else if (clf)    begin m_flg = 0; m_fbf = 0; end
            if (cmd_wr) m_word = cmd_wdata;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && m_valid) begin
            chk("R1 model start_vld", start_vld, m_sv);
            if (m_sv) begin
                chk("R1 model start_xch", start_xch, m_sx);
                chk("R1 model start_fn",  start_fn,  m_sf);
                chk("R1 model start_drv", start_drv, m_sd);
            end
            chk("R7 model abort",     abort,    m_ab);
            chk("R4 model busy",      busy,     m_busy);
            chk("R13 model xfer",     xfer,     m_xfer);
            chk("R6 model poll",      poll,     m_poll);
            chk("R3 model ctl",       ctl,      m_ctl);
            chk("R2 model cmd",       cmd,      m_cmd);
            chk("R5 model flag",      flag,     m_flg);
            chk("R14 model flag_buf", flag_buf, m_fbf);
            chk("R9 model dch_flag",  dch_flag, m_dch);
            chk("R12 model attn",     attn,     m_attn);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic put_word(logic [15:0] w);
        cmd_wr = 1; cmd_wdata = w; cyc(); cmd_wr = 0;
    endtask

    task automatic pulse_stc();  stc = 1;      cyc(); stc = 0;      endtask
    task automatic pulse_clc();  clc = 1;      cyc(); clc = 0;      endtask
    task automatic pulse_clf();  clf = 1;      cyc(); clf = 0;      endtask
    task automatic pulse_xch();  xch_done = 1; cyc(); xch_done = 0; endtask
    task automatic pulse_op();   op_done = 1;  cyc(); op_done = 0;  endtask
    task automatic pulse_seek(logic [1:0] d);
        seek_done = 1; seek_drv = d; cyc(); seek_done = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        // R10 reset state
        chk("R10 busy", busy, 0);           chk("R10 cmd", cmd, 0);
        chk("R10 ctl", ctl, 0);             chk("R10 poll", poll, 0);
        chk("R10 flag", flag, 1);           chk("R10 flag_buf", flag_buf, 1);
        chk("R10 dch_flag", dch_flag, 1);   chk("R10 attn", attn, 0);
        chk("R10 start_vld", start_vld, 0);

        // R14 host flag strobes
        pulse_clf(); chk("R14 clf flag", flag, 0); chk("R14 clf flag_buf", flag_buf, 0);
        stf = 1; cyc(); stf = 0; chk("R14 stf flag", flag, 1);
        pulse_clf();

        // R1 / R4 read on drive 2
        put_word(16'h2002);
        pulse_stc();
        chk("R1 start pulse", start_vld, 1); chk("R1 start_xch", start_xch, 0);
        chk("R1 start_fn", start_fn, 2);     chk("R1 start_drv", start_drv, 2);
        chk("R4 busy", busy, 3);             chk("R4 xfer", xfer, 1);
        chk("R3 ctl", ctl, 1);               chk("R3 cmd", cmd, 1);
        cyc(); chk("R1 pulse single cycle", start_vld, 0);

        // R2 start while command set
        put_word(16'h1001);
        pulse_stc();
        chk("R2 no pulse", start_vld, 0); chk("R2 busy kept", busy, 3);

        // R13 transfer end
        xfer_end = 1; cyc(); xfer_end = 0;
        chk("R13 xfer", xfer, 0); chk("R13 busy", busy, 3);

        // R5 operation done
        pulse_op();
        chk("R5 busy", busy, 0); chk("R5 attn", attn, 4'b0100);
        chk("R5 flag", flag, 1); chk("R5 cmd", cmd, 0);

        // R8 read port
        rd_load = 1; rd_in = 16'hFF00; #1;
        chk("R8 load", rd_out, 16'h0004);
        rd_load = 0; rd_in = 16'hA0A0; #1;
        chk("R8 merge", rd_out, 16'hA0A4);
        rd_in = 16'h0000;
        pulse_clf();

        // R6 seek with polling
        put_word(16'h3001);
        pulse_stc();
        chk("R6 seek start_xch", start_xch, 1); chk("R6 poll set", poll, 1);
        pulse_xch();
        chk("R6 cmd held after exchange", cmd, 1);
        pulse_seek(2'd1);
        chk("R6 attn", attn, 4'b0110); chk("R6 flag", flag, 1); chk("R6 cmd", cmd, 0);

        // R7 abort, then seek completion without polling
        pulse_clc();
        chk("R7 poll", poll, 0); chk("R7 ctl", ctl, 0); chk("R7 abort", abort, 1);
        pulse_clf();
        pulse_seek(2'd3);
        chk("R6 attn no poll", attn, 4'b1110); chk("R6 no flag", flag, 0);

        // R9 status reads
        put_word(16'h0003);
        pulse_stc();
        chk("R9 dch cleared", dch_flag, 0); chk("R9 fn", start_fn, 0);
        pulse_xch();
        chk("R9 dch set", dch_flag, 1); chk("R9 attn", attn, 4'b0110);
        chk("R9 poll", poll, 1); chk("R9 flag others", flag, 1); chk("R9 cmd", cmd, 0);
        pulse_clf();
        put_word(16'h0001); pulse_stc(); pulse_xch();
        chk("R9 attn2", attn, 4'b0100); chk("R9 flag2", flag, 1);
        pulse_clf();
        put_word(16'h0002); pulse_stc(); pulse_xch();
        chk("R9 attn3", attn, 4'b0000); chk("R9 no flag", flag, 0);

        // R11 check data on drive 0
        put_word(16'h6000);
        pulse_stc();
        chk("R11 first pulse xch", start_xch, 1); chk("R11 fn", start_fn, 6);
        pulse_xch();
        chk("R11 second pulse", start_vld, 1); chk("R11 second kind", start_xch, 0);
        chk("R11 second fn", start_fn, 6);     chk("R11 busy", busy, 1);
        chk("R11 xfer", xfer, 1);
        pulse_op();
        chk("R11 attn", attn, 4'b0001); chk("R11 free", busy, 0);
        pulse_clf();

        // R12 address record on drive 2
        put_word(16'hB002);
        pulse_stc(); pulse_xch();
        chk("R12 attn", attn, 4'b0101); chk("R12 flag", flag, 1); chk("R12 cmd", cmd, 0);

        // R7 abort while running
        put_word(16'h2003);
        pulse_stc();
        chk("R4 busy drive3", busy, 4);
        pulse_clc();
        chk("R7 busy", busy, 0); chk("R7 xfer", xfer, 0); chk("R7 abort pulse", abort, 1);
        cyc(); chk("R7 abort ends", abort, 0);

        // R1 unknown code
        put_word(16'h4001);
        pulse_stc();
        chk("R1 unknown cmd", cmd, 1); chk("R1 unknown no pulse", start_vld, 0);
        chk("R1 unknown busy", busy, 0);
        pulse_clc();
        repeat (3) cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule